// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC. It examines the six destination-address bytes at the head of each incoming frame and produces a single accept/reject verdict. The verdict is based on the kind of address seen:

- An individual (unicast) address is accepted only when it equals a programmed 48-bit station address.
- A group (multicast) address is accepted when its bit is set in a 64-entry hash table. The entry is selected by a CRC-32 taken over the address.
- The all-ones broadcast address is always accepted.
- A promiscuous control bit forces acceptance of every frame.

The address bytes arrive as a byte stream. A strobe marks the first byte of each frame. A byte-wide configuration write port loads five registers: the station address in two words, the hash table in two words, and the control word.

The verdict is registered and appears one clock after the sixth byte. It then holds steady until the next frame starts, so the downstream receive logic can sample it at its leisure.

Top module: `dst_addr_filter`

## Requirements
- R1: A destination whose first byte has bit 0 clear is accepted only when all six bytes equal the station address. The first byte on the wire is station byte 0. Bytes 0..3 come from the station-low word: byte 0 in bits 31:24 through byte 3 in bits 7:0. Bytes 4 and 5 come from the station-high word, in bits 31:24 and 23:16.
- R2: A configuration write with `cfg_we` high updates the selected register at the clock edge. The register is selected by `cfg_sel`: 0 station-low, 1 station-high, 2 hash-low, 3 hash-high, 4 control.
- R3: A destination whose first byte has bit 0 set is a group address. It is decided by the hash table alone; the station address plays no part.
- R4: The hash is a CRC over the six bytes with the following rules:
  - The CRC starts at 0xFFFFFFFF and uses the reflected polynomial 0xEDB88320.
  - Each byte is fed least-significant bit first, one bit per step, and the result is not inverted.
  - The index is crc[31:26].
  - An index of 32..63 selects bit (index-32) of hash-high; an index of 0..31 selects bit (index) of hash-low.
- R5: Control bit 0 (promiscuous) set makes every frame accepted.
- R6: The destination FF:FF:FF:FF:FF:FF is always accepted, whatever the hash table holds.
- R7: `decision_valid` rises one clock after the sixth byte is taken. Both it and `accept` hold until the next start strobe. A start strobe clears `decision_valid`, even in the middle of a frame, and begins a new address.
- R8: After reset the station, hash and control registers are zero and `decision_valid` is low.
- R9: Bytes presented without a start strobe while no frame is in progress, or after the sixth byte, have no effect on the outputs.
- R10: With both hash words all ones, every group address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | An address byte is present |
| byte_first | input | 1 | Start strobe: this byte is byte 0 of a new frame |
| byte_data | input | 8 | Address byte |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Register select (see R2) |
| cfg_wdata | input | 32 | Configuration write data |
| decision_valid | output | 1 | Verdict is valid |
| accept | output | 1 | 1 = keep the frame, 0 = drop it |

## Verification
The hardest case to reach from the ports is a group address whose hash index lands on one particular table bit. Only a specific address makes the CRC point at a chosen bit in the high or the low word.

The bench handles this with its own CRC model. It searches random group addresses until it finds ones that index each word. It then arms exactly that bit, or every bit but that one, so each word's selection is shown to matter.

Random frames then mix station hits, near misses, broadcast and group addresses against random tables and promiscuous settings. Directed cases cover a mid-frame restart and trailing bytes.

// File: rtl/daf_pkg.sv
package daf_pkg;

  localparam int unsigned CRC_W     = 32;
  localparam int unsigned HASH_IDXW = 6;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    SEL_STA_LO  = 3'd0,
    SEL_STA_HI  = 3'd1,
    SEL_HASH_LO = 3'd2,
    SEL_HASH_HI = 3'd3,
    SEL_CTRL    = 3'd4
  } cfg_sel_e;

  // one byte through the reflected CRC, lsb first
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c_in,
                                                input logic [7:0] d_in);
    logic [CRC_W-1:0] c;
    logic [7:0]       d;
    c = c_in;
    d = d_in;
    for (int b = 0; b < 8; b++) begin
      c = (c >> 1) ^ (((c[0] ^ d[0]) == 1'b1) ? CRC_POLY : '0);
      d = d >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs
  import daf_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] sta_lo,
  output logic [REG_W-1:0] sta_hi,
  output logic [REG_W-1:0] hash_lo,
  output logic [REG_W-1:0] hash_hi,
  output logic             promisc
);

  logic [REG_W-1:0] sta_lo_q, sta_lo_d, sta_hi_q, sta_hi_d;
  logic [REG_W-1:0] hash_lo_q, hash_lo_d, hash_hi_q, hash_hi_d;
  logic             prom_q, prom_d;

  always_comb begin
    sta_lo_d  = sta_lo_q;
    sta_hi_d  = sta_hi_q;
    hash_lo_d = hash_lo_q;
    hash_hi_d = hash_hi_q;
    prom_d    = prom_q;
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_STA_LO:  sta_lo_d  = cfg_wdata;
        SEL_STA_HI:  sta_hi_d  = cfg_wdata;
        SEL_HASH_LO: hash_lo_d = cfg_wdata;
        SEL_HASH_HI: hash_hi_d = cfg_wdata;
        SEL_CTRL:    prom_d    = cfg_wdata[0];
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_lo_q  <= '0;
      sta_hi_q  <= '0;
      hash_lo_q <= '0;
      hash_hi_q <= '0;
      prom_q    <= 1'b0;
    end else begin
      sta_lo_q  <= sta_lo_d;
      sta_hi_q  <= sta_hi_d;
      hash_lo_q <= hash_lo_d;
      hash_hi_q <= hash_hi_d;
      prom_q    <= prom_d;
    end
  end

  assign sta_lo  = sta_lo_q;
  assign sta_hi  = sta_hi_q;
  assign hash_lo = hash_lo_q;
  assign hash_hi = hash_hi_q;
  assign promisc = prom_q;

  // R2: a hash-high write lands on the next edge
  a_r2_hash_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_HASH_HI) |=> (hash_hi_q == $past(cfg_wdata)));

  // R2: no write leaves the station low word untouched
  a_r2_sta_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(sta_lo_q));

endmodule

// File: rtl/daf_seq.sv
module daf_seq #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic             byte_first,
  output logic             take,
  output logic             first_take,
  output logic             last_take,
  output logic [CNT_W-1:0] idx
);

  localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    first_take = byte_valid && byte_first;
    take       = byte_valid && (byte_first || (cnt_q < IDLE_CNT));
    idx        = byte_first ? '0 : cnt_q;
    last_take  = take && (idx == LAST_IDX);
    cnt_d      = take ? (idx + 1'b1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= IDLE_CNT;
    else        cnt_q <= cnt_d;
  end

  // R9: the byte position never runs past the address length
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= IDLE_CNT);

  // R9: when idle, a byte without a strobe is not taken
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == IDLE_CNT && !byte_first) |=> (cnt_q == IDLE_CNT));

endmodule

// File: rtl/daf_hash_crc.sv
module daf_hash_crc
  import daf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first_take,
  input  logic [7:0]       data,
  output logic [CRC_W-1:0] crc_next
);

  logic [CRC_W-1:0] crc_q, crc_base;

  always_comb begin
    crc_base = first_take ? CRC_INIT : crc_q;
    crc_next = crc_byte(crc_base, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= CRC_INIT;
    else if (take) crc_q <= crc_next;
  end

  // R4: the accumulator changes only while bytes are taken
  a_r4_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(crc_q));

endmodule

// File: rtl/daf_addr_match.sv
module daf_addr_match #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1),
  localparam int unsigned ADDR_W = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first_take,
  input  logic [CNT_W-1:0]  idx,
  input  logic [7:0]        data,
  input  logic [ADDR_W-1:0] station,
  output logic              uni_next,
  output logic              bcast_next,
  output logic              group_next
);

  logic       eq_q, ones_q, grp_q;
  logic [7:0] sta_byte;
  logic       eq_base, ones_base;

  always_comb begin
    sta_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (idx == CNT_W'(i)) sta_byte = station[8*(ADDR_BYTES-1-i) +: 8];
    end
    eq_base    = first_take ? 1'b1 : eq_q;
    ones_base  = first_take ? 1'b1 : ones_q;
    uni_next   = eq_base && (data == sta_byte);
    bcast_next = ones_base && (data == 8'hFF);
    group_next = first_take ? data[0] : grp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q   <= 1'b0;
      ones_q <= 1'b0;
      grp_q  <= 1'b0;
    end else if (take) begin
      eq_q   <= uni_next;
      ones_q <= bcast_next;
      grp_q  <= group_next;
    end
  end

  // R1: a mismatch mid-address can never be undone
  a_r1_mismatch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !first_take && !eq_q) |-> !uni_next);

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import daf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned REG_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic             byte_first,
  input  logic [7:0]       byte_data,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic             decision_valid,
  output logic             accept
);

  localparam int unsigned CNT_W    = $clog2(ADDR_BYTES + 1);
  localparam int unsigned ADDR_W   = 8 * ADDR_BYTES;
  localparam int unsigned WSEL_W   = $clog2(REG_W);

  logic [REG_W-1:0]  sta_lo, sta_hi, hash_lo, hash_hi;
  logic              promisc;
  logic              take, first_take, last_take;
  logic [CNT_W-1:0]  idx;
  logic [CRC_W-1:0]  crc_next;
  logic              uni_next, bcast_next, group_next;
  logic [ADDR_W-1:0] station;
  logic [HASH_IDXW-1:0] hidx;
  logic              hash_hit, verdict;
  logic              dv_q, dv_d, acc_q, acc_d;

  assign station = {sta_lo, sta_hi[REG_W-1 -: (ADDR_W-REG_W)]};

  daf_cfg_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sta_lo(sta_lo), .sta_hi(sta_hi),
    .hash_lo(hash_lo), .hash_hi(hash_hi), .promisc(promisc)
  );

  daf_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_first(byte_first),
    .take(take), .first_take(first_take), .last_take(last_take), .idx(idx)
  );

  daf_hash_crc u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .first_take(first_take),
    .data(byte_data), .crc_next(crc_next)
  );

  daf_addr_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
    .clk(clk), .rst_n(rst_n), .take(take), .first_take(first_take), .idx(idx),
    .data(byte_data), .station(station), .uni_next(uni_next),
    .bcast_next(bcast_next), .group_next(group_next)
  );

  always_comb begin
    hidx     = crc_next[CRC_W-1 -: HASH_IDXW];
    hash_hit = hidx[HASH_IDXW-1] ? hash_hi[hidx[WSEL_W-1:0]]
                                 : hash_lo[hidx[WSEL_W-1:0]];
    verdict  = promisc || bcast_next || (group_next ? hash_hit : uni_next);
    dv_d     = dv_q;
    acc_d    = acc_q;
    if (first_take) dv_d = 1'b0;
    if (last_take) begin
      dv_d  = 1'b1;
      acc_d = verdict;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      dv_q  <= dv_d;
      acc_q <= acc_d;
    end
  end

  assign decision_valid = dv_q;
  assign accept         = acc_q;

  // R7: the verdict follows the final byte by one clock
  a_r7_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> dv_q);

  // R7: verdict holds until a new start strobe
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_q && !first_take) |=> (dv_q && $stable(acc_q)));

  // R5: promiscuous mode forces acceptance
  a_r5_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take && promisc) |=> acc_q);

  // R6: broadcast is always accepted
  a_r6_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take && bcast_next) |=> acc_q);

endmodule

// File: tb/dst_addr_filter_tb.sv
module dst_addr_filter_tb;

  logic        clk;
  logic        rst_n;
  logic        byte_valid, byte_first;
  logic [7:0]  byte_data;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        decision_valid, accept;

  int unsigned n_checks;
  int unsigned n_fail;

  logic [47:0] m_sta;
  logic [31:0] m_hlo, m_hhi;
  logic        m_prom;

  dst_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_first(byte_first),
    .byte_data(byte_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .decision_valid(decision_valid), .accept(accept)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int unsigned hash_idx(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  d;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      d = a[47-8*i -: 8];
      for (int b = 0; b < 8; b++) begin
        if ((c[0] ^ d[0]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
        else                       c = c >> 1;
        d = d >> 1;
      end
    end
    return int'(c[31:26]);
  endfunction

  function automatic logic exp_accept(input logic [47:0] a);
    int unsigned h;
    if (m_prom) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (a[40]) begin
      h = hash_idx(a);
      return (h >= 32) ? m_hhi[h-32] : m_hlo[h];
    end
    return (a == m_sta);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: m_sta[47:16] = val;
      3'd1: m_sta[15:0]  = val[31:16];
      3'd2: m_hlo = val;
      3'd3: m_hhi = val;
      3'd4: m_prom = val[0];
      default: ;
    endcase
  endtask

  task automatic set_station(input logic [47:0] s);
    cfg_write(3'd0, s[47:16]);
    cfg_write(3'd1, {s[15:0], 16'h0});
  endtask

  task automatic send_bytes(input logic [47:0] a, input int unsigned n);
    for (int i = 0; i < int'(n); i++) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_first = (i == 0); byte_data = a[47-8*i -: 8];
    end
    @(negedge clk);
    byte_valid = 1'b0; byte_first = 1'b0;
  endtask

  task automatic frame_check(input logic [47:0] a, input string req);
    logic e;
    e = exp_accept(a);
    send_bytes(a, 6);
    check(decision_valid === 1'b1, req, {31'd0, decision_valid}, 32'd1);
    check(accept === e, req, {31'd0, accept}, {31'd0, e});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [47:0] a, a_hi, a_lo;
    logic        held;
    int unsigned h;
    n_checks = 0; n_fail = 0;
    m_sta = '0; m_hlo = '0; m_hhi = '0; m_prom = 1'b0;
    rst_n = 1'b0; byte_valid = 1'b0; byte_first = 1'b0; byte_data = '0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    check(decision_valid === 1'b0, "R8 valid low", {31'd0, decision_valid}, 32'd0);
    // R9: bytes without a start strobe are ignored
    @(negedge clk); byte_valid = 1'b1; byte_data = 8'h12;
    repeat (8) @(negedge clk);
    byte_valid = 1'b0;
    @(negedge clk);
    check(decision_valid === 1'b0, "R9 no strobe", {31'd0, decision_valid}, 32'd0);
    // R8: zero station matches all-zero unicast; empty hash rejects group
    frame_check(48'h0000_0000_0000, "R8 station zero");
    frame_check(48'h0100_5E00_0001, "R8 hash zero");

    // R1: exact unicast match and single-byte misses
    set_station(48'h0204_9F01_30E0);
    frame_check(48'h0204_9F01_30E0, "R1 match");
    frame_check(48'h0204_9F01_30E1, "R1 last byte differs");
    frame_check(48'h0A04_9F01_30E0, "R1 first byte differs");
    frame_check(48'h0204_9F11_30E0, "R1 middle byte differs");

    // R3: group address equal to station is still decided by hash only
    set_station(48'h0304_0506_0708);
    frame_check(48'h0304_0506_0708, "R3 group ignores station");

    // R4: find group addresses hashing into each word
    a_hi = '0; a_lo = '0;
    for (int k = 0; k < 2000; k++) begin
      a = {$urandom(), $urandom()};
      a[40] = 1'b1;
      if (a != 48'hFFFF_FFFF_FFFF) begin
        h = hash_idx(a);
        if (h >= 32 && a_hi == '0) a_hi = a;
        if (h < 32 && a_lo == '0) a_lo = a;
      end
    end
    h = hash_idx(a_hi);
    cfg_write(3'd3, 32'h1 << (h - 32));
    cfg_write(3'd2, 32'h0);
    frame_check(a_hi, "R4 high word bit set");
    cfg_write(3'd3, ~(32'h1 << (h - 32)));
    cfg_write(3'd2, 32'hFFFF_FFFF);
    frame_check(a_hi, "R4 high word bit clear");
    h = hash_idx(a_lo);
    cfg_write(3'd2, 32'h1 << h);
    cfg_write(3'd3, 32'h0);
    frame_check(a_lo, "R4 low word bit set");
    cfg_write(3'd2, ~(32'h1 << h));
    cfg_write(3'd3, 32'hFFFF_FFFF);
    frame_check(a_lo, "R4 low word bit clear");

    // R6: broadcast with empty table
    cfg_write(3'd2, 32'h0);
    cfg_write(3'd3, 32'h0);
    frame_check(48'hFFFF_FFFF_FFFF, "R6 broadcast");
    // R10: all-ones table accepts group traffic
    cfg_write(3'd2, 32'hFFFF_FFFF);
    cfg_write(3'd3, 32'hFFFF_FFFF);
    frame_check(a_lo, "R10 all ones");
    frame_check(48'h3333_0000_0001, "R10 all ones");
    // R5: promiscuous accepts a mismatching unicast
    cfg_write(3'd2, 32'h0);
    cfg_write(3'd3, 32'h0);
    cfg_write(3'd4, 32'h1);
    frame_check(48'h0A0B_0C0D_0E0F, "R5 promiscuous");
    cfg_write(3'd4, 32'h0);
    frame_check(48'h0A0B_0C0D_0E0F, "R5 promiscuous off");

    // R7/R9: verdict holds, trailing bytes ignored
    set_station(48'h0011_2233_4455);
    frame_check(48'h0011_2233_4455, "R7 accept");
    held = accept;
    @(negedge clk); byte_valid = 1'b1; byte_first = 1'b0; byte_data = 8'h99;
    repeat (4) @(negedge clk);
    byte_valid = 1'b0;
    @(negedge clk);
    check(decision_valid === 1'b1 && accept === held, "R9 trailing bytes",
          {30'd0, decision_valid, accept}, {30'd0, 1'b1, held});
    // R7: start strobe clears valid; restart mid-frame
    @(negedge clk); byte_valid = 1'b1; byte_first = 1'b1; byte_data = 8'h00;
    @(negedge clk); byte_first = 1'b0; byte_data = 8'h11;
    check(decision_valid === 1'b0, "R7 strobe clears", {31'd0, decision_valid}, 32'd0);
    byte_valid = 1'b0;
    frame_check(48'h0011_2233_4456, "R7 restart");
    frame_check(48'h0011_2233_4455, "R7 restart");

    // R2/R1/R3/R4: random configurations and addresses
    for (int r = 0; r < 300; r++) begin
      if (r % 20 == 0) begin
        set_station({$urandom(), $urandom()} & 48'hFEFF_FFFF_FFFF);
        cfg_write(3'd2, $urandom());
        cfg_write(3'd3, $urandom());
        cfg_write(3'd4, {31'd0, ($urandom() % 8) == 0});
      end
      case ($urandom() % 5)
        0: a = m_sta;
        1: begin a = m_sta; a[$urandom() % 48] ^= 1'b1; end
        2: a = 48'hFFFF_FFFF_FFFF;
        3: begin a = {$urandom(), $urandom()}; a[40] = 1'b1; end
        default: a = {$urandom(), $urandom()};
      endcase
      frame_check(a, "R2 R1 R3 R4 random");
    end

    finish_run();
  end

endmodule